// File: doc/BRIEF.md
# Mode-Selectable Master Clock Divider

This block turns a fast master clock into the two serial-audio timing clocks: a bit clock at 64 times the frame rate and a frame clock at the frame rate. A 3-bit mode code picks how the master clock relates to the frame rate: 256, 384, 512 or 768 times. The bit clock is therefore the master clock divided by 4, 6, 8 or 12. Both generated clocks are registers in the master clock domain, and each has an exact 50% duty cycle.

Some mode codes select slave operation. In those modes the generated clocks stay low and a slave flag is raised. Other codes are reserved; they raise an error flag and also keep the clocks low. A power-down input and any change of the mode code put the dividers back to their low phase. For each falling edge of the bit clock, the block gives a downstream serializer a one-master-clock strobe.

Top module: `mcd_clkdiv`

## Requirements
- R1: Mode codes 0 and 4 are slave modes. `slave_o` is 1 while either code is applied. From the first master clock edge that samples such a code, `bclk_o`, `fclk_o` and `bclk_fall_stb_o` stay 0.
- R2: Mode codes 1 and 5 are reserved. `mode_err_o` is 1 while either code is applied. From the first edge that samples such a code, all three clock outputs stay 0.
- R3: The master codes set the bit clock period in master clock cycles: code 2 gives 4, code 6 gives 6, code 3 gives 8 and code 7 gives 12. Each bit clock period is low for exactly half its cycles and high for the other half. Counting starts in the low phase.
- R4: The frame clock starts low. It changes only at the edge where the bit clock falls, once every 32 bit clock periods, so one frame is 64 bit clock periods with a 50% duty cycle.
- R5: `bclk_fall_stb_o` is 1 for exactly one master clock cycle: the first cycle in which `bclk_o` reads 0 after reading 1.
- R6: While `pwr_dn_i` is 1, all three clock outputs are 0 from the next edge onward. After release, the divider counts again from the start of a low phase.
- R7: An edge that samples a mode code different from the one sampled at the previous edge clears all three clock outputs. Counting for the new code starts at the following edge.
- R8: While `rst_ni` is 0, all three clock outputs are 0 at once, without waiting for a clock edge.
- R9: `slave_o` and `mode_err_o` follow the applied mode code without a clock delay. At most one of them is 1, and both are 0 for the master codes 2, 3, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_i | input | 1 | Power-down: holds the clock outputs low |
| mode_sel_i | input | 3 | Mode code |
| bclk_o | output | 1 | Generated bit clock (64 per frame) |
| fclk_o | output | 1 | Generated frame clock |
| bclk_fall_stb_o | output | 1 | One-cycle strobe on each bit clock fall |
| slave_o | output | 1 | Slave mode is applied |
| mode_err_o | output | 1 | Reserved mode code is applied |

## Verification
The hardest situation to reach is a mode change or power-down in the middle of a running frame, because the restart must land exactly on a low phase at the right edge. The stimulus runs each master ratio for two full frames, then, at chosen points mid-frame, asserts power-down, switches directly between master ratios, and moves from a running master code into slave and reserved codes. For each of these events the scoreboard expects a precise sequence of cleared cycles followed by a fresh divide pattern.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;

   localparam int MODE_W   = 3;
   localparam int N_MODES  = 1 << MODE_W;
   localparam int HALF_MAX = 6;
   localparam int HALF_W   = $clog2(HALF_MAX + 1);

   typedef enum logic [1:0] {
      MK_SLAVE  = 2'd0,
      MK_RSVD   = 2'd1,
      MK_MASTER = 2'd2
   } mode_kind_e;

   // classification of each mode code
   function automatic mode_kind_e kind_of(input int code);
      case (code)
         0, 4:    return MK_SLAVE;
         1, 5:    return MK_RSVD;
         default: return MK_MASTER;
      endcase
   endfunction

   // master clock cycles per bit clock half period
   function automatic logic [HALF_W-1:0] half_of(input int code);
      case (code)
         2:       return HALF_W'(2);
         6:       return HALF_W'(3);
         3:       return HALF_W'(4);
         7:       return HALF_W'(6);
         default: return HALF_W'(0);
      endcase
   endfunction

endpackage

// File: rtl/mcd_mode_decode.sv
`timescale 1ns/1ps
module mcd_mode_decode
   import mcd_pkg::*;
(
   input  logic [MODE_W-1:0] mode_sel_i,
   output logic              is_slave_o,
   output logic              is_rsvd_o,
   output logic              is_master_o,
   output logic [HALF_W-1:0] half_cnt_o
);

   logic [N_MODES-1:0] hit;
   logic [N_MODES-1:0] slave_v;
   logic [N_MODES-1:0] rsvd_v;
   logic [N_MODES-1:0] master_v;
   logic [HALF_W-1:0]  half_t [N_MODES];

   for (genvar c = 0; c < N_MODES; c++) begin : g_code
      localparam mode_kind_e        KIND = kind_of(c);
      localparam logic [HALF_W-1:0] HALF = half_of(c);
      assign hit[c]      = (mode_sel_i == MODE_W'(c));
      assign slave_v[c]  = hit[c] && (KIND == MK_SLAVE);
      assign rsvd_v[c]   = hit[c] && (KIND == MK_RSVD);
      assign master_v[c] = hit[c] && (KIND == MK_MASTER);
      assign half_t[c]   = hit[c] ? HALF : '0;
   end

   always_comb begin
      half_cnt_o = '0;
      for (int i = 0; i < N_MODES; i++) begin
         half_cnt_o = half_cnt_o | half_t[i];
      end
   end

   assign is_slave_o  = |slave_v;
   assign is_rsvd_o   = |rsvd_v;
   assign is_master_o = |master_v;

endmodule

// File: rtl/mcd_bclk_div.sv
`timescale 1ns/1ps
module mcd_bclk_div #(
   parameter int HALF_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [HALF_W-1:0] half_cnt_i,
   output logic              bclk_o,
   output logic              fall_evt_o,
   output logic              fall_stb_o
);

   logic [HALF_W-1:0] hc_q;
   logic              bclk_q;
   logic              stb_q;
   logic              last;

   assign last       = (hc_q == (half_cnt_i - HALF_W'(1)));
   assign fall_evt_o = run_i && last && bclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hc_q   <= '0;
         bclk_q <= 1'b0;
         stb_q  <= 1'b0;
      end else if (!run_i) begin
         hc_q   <= '0;
         bclk_q <= 1'b0;
         stb_q  <= 1'b0;
      end else begin
         stb_q <= fall_evt_o;
         if (last) begin
            hc_q   <= '0;
            bclk_q <= ~bclk_q;
         end else begin
            hc_q <= hc_q + HALF_W'(1);
         end
      end
   end

   assign bclk_o     = bclk_q;
   assign fall_stb_o = stb_q;

endmodule

// File: rtl/mcd_fclk_div.sv
`timescale 1ns/1ps
module mcd_fclk_div #(
   parameter int FALLS_PER_PHASE = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic fall_evt_i,
   output logic fclk_o
);

   localparam int CW = (FALLS_PER_PHASE > 1) ? $clog2(FALLS_PER_PHASE) : 1;

   logic [CW-1:0] cnt_q;
   logic          fclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         fclk_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         fclk_q <= 1'b0;
      end else if (fall_evt_i) begin
         if (cnt_q == CW'(FALLS_PER_PHASE - 1)) begin
            cnt_q  <= '0;
            fclk_q <= ~fclk_q;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign fclk_o = fclk_q;

endmodule

// File: rtl/mcd_clkdiv.sv
`timescale 1ns/1ps
module mcd_clkdiv
   import mcd_pkg::*;
#(
   parameter int BCLK_PER_FRAME = 64,
   parameter bit REG_FLAGS      = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pwr_dn_i,
   input  logic [MODE_W-1:0] mode_sel_i,
   output logic              bclk_o,
   output logic              fclk_o,
   output logic              bclk_fall_stb_o,
   output logic              slave_o,
   output logic              mode_err_o
);

   localparam int FALLS_PER_PHASE = BCLK_PER_FRAME / 2;

   if ((BCLK_PER_FRAME < 2) || ((BCLK_PER_FRAME % 2) != 0)) begin : g_bad_frame
      initial $fatal(1, "BCLK_PER_FRAME must be even and at least 2");
   end
   if (MODE_W != 3) begin : g_bad_mode_w
      initial $fatal(1, "mode table is defined for a 3-bit code");
   end

   logic              is_slave;
   logic              is_rsvd;
   logic              is_master;
   logic [HALF_W-1:0] half_cnt;
   logic [MODE_W-1:0] mode_q;
   logic              mode_chg;
   logic              run;
   logic              fall_evt;

   mcd_mode_decode u_dec (
      .mode_sel_i  (mode_sel_i),
      .is_slave_o  (is_slave),
      .is_rsvd_o   (is_rsvd),
      .is_master_o (is_master),
      .half_cnt_o  (half_cnt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= '0;
      else         mode_q <= mode_sel_i;
   end

   assign mode_chg = (mode_q != mode_sel_i);
   assign run      = is_master && !pwr_dn_i && !mode_chg;

   mcd_bclk_div #(.HALF_W(HALF_W)) u_bdiv (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run),
      .half_cnt_i (half_cnt),
      .bclk_o     (bclk_o),
      .fall_evt_o (fall_evt),
      .fall_stb_o (bclk_fall_stb_o)
   );

   mcd_fclk_div #(.FALLS_PER_PHASE(FALLS_PER_PHASE)) u_fdiv (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run),
      .fall_evt_i (fall_evt),
      .fclk_o     (fclk_o)
   );

   if (REG_FLAGS) begin : g_flags_reg
      logic slave_q, err_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            slave_q <= 1'b0;
            err_q   <= 1'b0;
         end else begin
            slave_q <= is_slave;
            err_q   <= is_rsvd;
         end
      end
      assign slave_o    = slave_q;
      assign mode_err_o = err_q;
   end else begin : g_flags_comb
      assign slave_o    = is_slave;
      assign mode_err_o = is_rsvd;
   end

endmodule

// File: rtl/mcd_clkdiv_chk.sv
`timescale 1ns/1ps
module mcd_clkdiv_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       pwr_dn_i,
   input logic [2:0] mode_sel_i,
   input logic       bclk_o,
   input logic       fclk_o,
   input logic       bclk_fall_stb_o,
   input logic       slave_o,
   input logic       mode_err_o
);

   AST_SLAVE_CLOCKS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slave_o |=> (!bclk_o && !fclk_o)); // R1

   AST_RSVD_CLOCKS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_err_o |=> (!bclk_o && !fclk_o && !bclk_fall_stb_o)); // R2

   AST_FCLK_RISE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fclk_o) |-> bclk_fall_stb_o); // R4

   AST_STB_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bclk_fall_stb_o |-> $fell(bclk_o)); // R5

   AST_PDN_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_dn_i |=> (!bclk_o && !fclk_o && !bclk_fall_stb_o)); // R6

   AST_MODE_CHANGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(mode_sel_i) |=> (!bclk_o && !fclk_o)); // R7

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({slave_o, mode_err_o})); // R9

endmodule

bind mcd_clkdiv mcd_clkdiv_chk u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .pwr_dn_i        (pwr_dn_i),
   .mode_sel_i      (mode_sel_i),
   .bclk_o          (bclk_o),
   .fclk_o          (fclk_o),
   .bclk_fall_stb_o (bclk_fall_stb_o),
   .slave_o         (slave_o),
   .mode_err_o      (mode_err_o)
);

// File: tb/mcd_clkdiv_tb_top.sv
`timescale 1ns/1ps
module mcd_clkdiv_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       pwr_dn;
   logic [2:0] mode;
   logic       bclk, fclk, stb, slave, err;

   always #10 clk = ~clk;

   mcd_clkdiv dut_i (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .pwr_dn_i        (pwr_dn),
      .mode_sel_i      (mode),
      .bclk_o          (bclk),
      .fclk_o          (fclk),
      .bclk_fall_stb_o (stb),
      .slave_o         (slave),
      .mode_err_o      (err)
   );

   // expected item: {bclk, fclk, strobe, slave, err}
   logic [4:0] exp_q [$];
   string      tag_q [$];
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   task automatic tick();
      @(posedge clk);
      #15;
   endtask

   task automatic drain();
      while (exp_q.size() > 0) tick();
   endtask

   task automatic push_zero(input int n, input bit sl, input bit er, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back({1'b0, 1'b0, 1'b0, sl, er});
         tag_q.push_back(tag);
      end
   endtask

   // e counts edges since the divider started, from 1
   task automatic push_run(input int h, input int n, input string tag);
      for (int e = 1; e <= n; e++) begin
         logic b, f, s;
         b = ((e / h) % 2) == 1;
         s = (e % (2 * h)) == 0;
         f = ((e / (64 * h)) % 2) == 1;
         exp_q.push_back({b, f, s, 1'b0, 1'b0});
         tag_q.push_back(tag);
      end
   endtask

   task automatic direct_check(input string tag);
      n_cmp++;
      if ({bclk, fclk, stb} !== 3'b000) begin
         n_bad++;
         $display("FAIL %s: clocks=%b expected 000", tag, {bclk, fclk, stb});
      end
   endtask

   // monitor: compares outputs 5 ns after each edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic [4:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ({bclk, fclk, stb, slave, err} !== e) begin
               n_bad++;
               $display("FAIL %s: bclk/fclk/stb/slave/err=%b expected %b", t,
                        {bclk, fclk, stb, slave, err}, e);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n  = 1'b0;
      pwr_dn = 1'b1;
      mode   = 3'd0;
      tick();
      tick();
      direct_check("R8 reset state");
      rst_n = 1'b1;
      tick();

      // R3 R4 R5 R9: two frames for each master ratio
      mode = 3'd2; tick(); tick(); pwr_dn = 1'b0; push_run(2, 512,  "R3 R4 R5 R9 code2"); drain();
      pwr_dn = 1'b1;
      mode = 3'd6; tick(); tick(); pwr_dn = 1'b0; push_run(3, 768,  "R3 R4 R5 R9 code6"); drain();
      pwr_dn = 1'b1;
      mode = 3'd3; tick(); tick(); pwr_dn = 1'b0; push_run(4, 1024, "R3 R4 R5 R9 code3"); drain();
      pwr_dn = 1'b1;
      mode = 3'd7; tick(); tick(); pwr_dn = 1'b0; push_run(6, 1536, "R3 R4 R5 R9 code7"); drain();

      // R6: power-down mid-frame, then restart from the low phase
      pwr_dn = 1'b1;
      mode = 3'd2; tick(); tick(); pwr_dn = 1'b0; push_run(2, 101, "R6 pre"); drain();
      pwr_dn = 1'b1; push_zero(8, 1'b0, 1'b0, "R6 held"); drain();
      pwr_dn = 1'b0; push_run(2, 300, "R6 restart"); drain();

      // R7: direct switch between master ratios while running
      mode = 3'd6; push_zero(1, 1'b0, 1'b0, "R7 clear"); push_run(3, 80, "R7 code6"); drain();
      mode = 3'd3; push_zero(1, 1'b0, 1'b0, "R7 clear"); push_run(4, 45, "R7 code3"); drain();

      // R1: running master into slave codes
      mode = 3'd0; push_zero(6, 1'b1, 1'b0, "R1 code0"); drain();
      mode = 3'd7; push_zero(1, 1'b0, 1'b0, "R7 clear"); push_run(6, 40, "R7 code7"); drain();
      mode = 3'd4; push_zero(6, 1'b1, 1'b0, "R1 code4"); drain();

      // R2: running master into reserved codes
      mode = 3'd2; push_zero(1, 1'b0, 1'b0, "R7 clear"); push_run(2, 23, "R7 code2"); drain();
      mode = 3'd1; push_zero(6, 1'b0, 1'b1, "R2 code1"); drain();
      mode = 3'd5; push_zero(6, 1'b0, 1'b1, "R2 code5"); drain();

      // R8: asynchronous reset while running
      mode = 3'd2; push_zero(1, 1'b0, 1'b0, "R7 clear"); push_run(2, 6, "R8 pre"); drain();
      #1;
      rst_n = 1'b0;
      #1;
      direct_check("R8 async reset");
      tick();
      rst_n = 1'b1;
      tick();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule